// File: doc/BRIEF.md
# Fault-hardened boot trust sequencer

This block is the control machine that walks a chip through its boot trust stages: idle, measuring, verified and booting. A start request opens measurement. A measurement-done strobe, qualified by a pass/fail result from an external checker, then either admits the chip to the verified stage or sends it to lockout. From verified the machine goes on to booting, where the boot-release output is held high. The hashing engine and the signature checker are outside the block and appear only as input strobes.

The block is built to resist fault injection. Each state is stored as a six-bit code: a five-bit body plus a parity bit that gives every legal code odd weight. Any single flipped bit therefore yields a code outside the legal set. Two identical copies of the machine run in lockstep on the same inputs. An integrity monitor flags an illegal code in either copy, or any difference between the two copies. Either condition drives both copies into a sticky lockout and raises a fault output in the same cycle. Lockout is left only through reset.

Top module: `boot_seq_guard`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, meas_en_o, verified_o, boot_rel_o, locked_o and fault_o are all low.
- R2: start_i sampled high in the idle stage moves the machine to measuring from the next cycle. meas_en_o is high exactly while both copies are in measuring.
- R3: meas_done_i with meas_pass_i high, sampled in measuring, makes verified_o high for exactly one cycle. boot_rel_o then goes high in the following cycle and stays high.
- R4: meas_done_i with meas_pass_i low, sampled in measuring, leads to lockout in the next cycle: locked_o goes high and fault_o stays low.
- R5: The booting stage is entered only from verified. meas_done_i in the idle stage, start_i in measuring, and either strobe in booting leave the outputs unchanged.
- R6: If either copy holds a code outside the legal set, fault_o goes high in that same cycle. The next cycle has locked_o high. The legal six-bit codes are idle 6'h23, measuring 6'h2C, verified 6'h15, booting 6'h1A and lockout 6'h1F. Examples of illegal codes are 6'h00 and 6'h2D, which is measuring with bit 0 flipped.
- R7: If the two copies hold different legal codes, for example one in verified (6'h15) while the other is idle or booting, fault_o goes high in that same cycle and locked_o is high from the next cycle.
- R8: Lockout is sticky. Once locked_o is high, it stays high and all enable outputs stay low under any input sequence until rst_ni is asserted. fault_o likewise stays high once set.
- R9: boot_rel_o is high only while both copies hold the booting code. A disagreement seen during booting drops boot_rel_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin the boot sequence |
| meas_done_i | input | 1 | Measurement and verification complete strobe |
| meas_pass_i | input | 1 | Verification result qualifying meas_done_i (1 = pass) |
| meas_en_o | output | 1 | Enables the measurement engine |
| verified_o | output | 1 | Verified stage reached |
| boot_rel_o | output | 1 | Boot release |
| locked_o | output | 1 | Machine is in lockout |
| fault_o | output | 1 | Integrity fault (illegal code or copy mismatch), sticky |

## Verification
The bench injects faults by depositing codes straight into one copy's state register between clock edges. It checks that fault_o rises before the next edge rather than one cycle later; a monitor placed behind a register would let a corrupted copy act for a cycle. It uses a single-bit flip of the measuring code, and it uses a legal but disagreeing code during booting. A parity-only check would miss the second, and a boot release decoded from one copy would keep releasing. It also sends strobes out of order (done before start, start during measuring, anything after lockout) to catch a machine that skips verification or lets an input leave lockout.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int unsigned BodyW = 5;
  localparam int unsigned StW   = BodyW + 1;

  typedef logic [StW-1:0] st_code_t;

  // {parity, body}; parity makes every legal code odd weight
  localparam st_code_t ST_IDLE = 6'h23;
  localparam st_code_t ST_MEAS = 6'h2C;
  localparam st_code_t ST_VERF = 6'h15;
  localparam st_code_t ST_BOOT = 6'h1A;
  localparam st_code_t ST_LOCK = 6'h1F;

  function automatic logic code_legal(st_code_t c);
    logic par_ok;
    logic in_set;
    par_ok = ^c;
    in_set = (c == ST_IDLE) || (c == ST_MEAS) || (c == ST_VERF) ||
             (c == ST_BOOT) || (c == ST_LOCK);
    return par_ok && in_set;
  endfunction
endpackage

// File: rtl/boot_seq_core.sv
module boot_seq_core
  import boot_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     meas_done_i,
  input  logic     meas_pass_i,
  input  logic     lock_i,
  output st_code_t state_o
);
  st_code_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (lock_i) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_MEAS;
        ST_MEAS: if (meas_done_i) state_d = meas_pass_i ? ST_VERF : ST_LOCK;
        ST_VERF: state_d = ST_BOOT;
        ST_BOOT: state_d = ST_BOOT;
        ST_LOCK: state_d = ST_LOCK;
        default: state_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/boot_seq_monitor.sv
module boot_seq_monitor
  import boot_seq_pkg::*;
(
  input  st_code_t state_a_i,
  input  st_code_t state_b_i,
  output logic     illegal_o,
  output logic     mismatch_o
);
  assign illegal_o  = !code_legal(state_a_i) || !code_legal(state_b_i);
  assign mismatch_o = (state_a_i != state_b_i);
endmodule

// File: rtl/boot_seq_guard.sv
module boot_seq_guard
  import boot_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic meas_done_i,
  input  logic meas_pass_i,
  output logic meas_en_o,
  output logic verified_o,
  output logic boot_rel_o,
  output logic locked_o,
  output logic fault_o
);
  st_code_t state_a, state_b;
  logic     illegal, mismatch, err_now, fault_q;

  boot_seq_core u_core_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .meas_done_i(meas_done_i), .meas_pass_i(meas_pass_i),
    .lock_i(err_now), .state_o(state_a)
  );

  boot_seq_core u_core_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .meas_done_i(meas_done_i), .meas_pass_i(meas_pass_i),
    .lock_i(err_now), .state_o(state_b)
  );

  boot_seq_monitor u_mon (
    .state_a_i(state_a), .state_b_i(state_b),
    .illegal_o(illegal), .mismatch_o(mismatch)
  );

  assign err_now = illegal || mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fault_q <= 1'b0;
    else if (err_now) fault_q <= 1'b1;
  end

  // enables need both copies to agree
  assign fault_o    = fault_q || err_now;
  assign meas_en_o  = (state_a == ST_MEAS) && (state_b == ST_MEAS);
  assign verified_o = (state_a == ST_VERF) && (state_b == ST_VERF);
  assign boot_rel_o = (state_a == ST_BOOT) && (state_b == ST_BOOT);
  assign locked_o   = (state_a == ST_LOCK) || (state_b == ST_LOCK) || fault_o;
endmodule

// File: rtl/boot_seq_sva.sv
module boot_seq_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic meas_done_i,
  input logic meas_pass_i,
  input logic meas_en_o,
  input logic verified_o,
  input logic boot_rel_o,
  input logic locked_o,
  input logic fault_o
);
  AST_ONE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({meas_en_o, verified_o, boot_rel_o, locked_o})); // R2

  AST_MEAS_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(meas_en_o) |-> $past(start_i)); // R2

  AST_PASS_TO_VERIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_en_o && meas_done_i && meas_pass_i && !fault_o |=> verified_o || fault_o); // R3

  AST_FAIL_TO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_en_o && meas_done_i && !meas_pass_i |=> locked_o); // R4

  AST_BOOT_ONLY_AFTER_VERIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boot_rel_o) |-> $past(verified_o)); // R5

  AST_FAULT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> locked_o && fault_o); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o && !meas_en_o && !verified_o && !boot_rel_o); // R8

  AST_NO_RELEASE_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !boot_rel_o); // R9
endmodule

bind boot_seq_guard boot_seq_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .meas_done_i(meas_done_i), .meas_pass_i(meas_pass_i),
  .meas_en_o(meas_en_o), .verified_o(verified_o), .boot_rel_o(boot_rel_o),
  .locked_o(locked_o), .fault_o(fault_o)
);

// File: tb/test_boot_seq_guard.sv
module test_boot_seq_guard;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, meas_done_i = 1'b0, meas_pass_i = 1'b0;
  logic meas_en_o, verified_o, boot_rel_o, locked_o, fault_o;
  int   total = 0;
  int   bad = 0;

  always #10 clk_i = ~clk_i;

  boot_seq_guard i_boot_seq_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .meas_done_i(meas_done_i), .meas_pass_i(meas_pass_i),
    .meas_en_o(meas_en_o), .verified_o(verified_o), .boot_rel_o(boot_rel_o),
    .locked_o(locked_o), .fault_o(fault_o)
  );

  // order: {meas_en, verified, boot_rel, locked, fault}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {meas_en_o, verified_o, boot_rel_o, locked_o, fault_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic st, input logic dn, input logic ps);
    start_i = st; meas_done_i = dn; meas_pass_i = ps;
    @(posedge clk_i); #2;
    start_i = 1'b0; meas_done_i = 1'b0; meas_pass_i = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk_i); #2;
    rst_ni = 1'b0;
    #3 chk("R1 in reset", 5'b00000);
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk("R1 after reset", 5'b00000);
  endtask

  task automatic inject_b(input logic [5:0] code);
    force i_boot_seq_guard.u_core_b.state_q = code;
    #1;
    release i_boot_seq_guard.u_core_b.state_q;
    #1;
  endtask

  task automatic inject_a(input logic [5:0] code);
    force i_boot_seq_guard.u_core_a.state_q = code;
    #1;
    release i_boot_seq_guard.u_core_a.state_q;
    #1;
  endtask

  task automatic t_happy();
    do_reset();
    step(1, 0, 0); chk("R2 measuring", 5'b10000);
    step(0, 0, 0); chk("R2 hold measuring", 5'b10000);
    step(1, 0, 0); chk("R5 start in measuring", 5'b10000);
    step(0, 1, 1); chk("R3 verified", 5'b01000);
    step(0, 0, 0); chk("R3 booting", 5'b00100);
    step(1, 1, 0); chk("R5 strobes in booting", 5'b00100);
    step(0, 1, 1); chk("R3 booting held", 5'b00100);
  endtask

  task automatic t_order();
    do_reset();
    step(0, 1, 1); chk("R5 done while idle", 5'b00000);
    step(0, 1, 0); chk("R5 fail while idle", 5'b00000);
    step(1, 0, 0); chk("R2 start after stray done", 5'b10000);
  endtask

  task automatic t_fail();
    do_reset();
    step(1, 0, 0);
    step(0, 1, 0); chk("R4 fail to lockout", 5'b00010);
    step(1, 0, 0); chk("R8 start in lockout", 5'b00010);
    step(0, 1, 1); chk("R8 pass in lockout", 5'b00010);
    do_reset();
  endtask

  task automatic t_illegal();
    do_reset();
    inject_a(6'h00);
    chk("R6 illegal code same cycle", 5'b00011);
    step(0, 0, 0); chk("R6 lockout after illegal", 5'b00011);
    step(1, 0, 0); chk("R8 start after fault", 5'b00011);
    step(0, 1, 1); chk("R8 pass after fault", 5'b00011);
    do_reset();
  endtask

  task automatic t_flip();
    do_reset();
    step(1, 0, 0);
    inject_b(6'h2D);
    chk("R6 single bit flip in measuring", 5'b00011);
    step(0, 1, 1); chk("R6 no verify after flip", 5'b00011);
  endtask

  task automatic t_mismatch();
    do_reset();
    step(1, 0, 0);
    step(0, 1, 1);
    step(0, 0, 0); chk("R9 boot before mismatch", 5'b00100);
    inject_b(6'h15);
    chk("R7 R9 mismatch drops release", 5'b00011);
    step(0, 0, 0); chk("R7 lockout after mismatch", 5'b00011);
    step(0, 0, 0); chk("R8 fault sticky", 5'b00011);
  endtask

  task automatic t_mismatch_idle();
    do_reset();
    inject_a(6'h15);
    chk("R7 legal mismatch at idle", 5'b00011);
    step(0, 0, 0); chk("R7 no boot after mismatch", 5'b00011);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_happy();
    t_order();
    t_fail();
    t_illegal();
    t_flip();
    t_mismatch();
    t_mismatch_idle();
    do_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule